// File: doc/BRIEF.md
# Layered OSD Plane Compositor

This block merges four on-screen-display planes over a backdrop video plane, one pixel per dot clock. For every dot it receives the backdrop colour, one raw pixel from each OSD plane and that plane's region attributes: indexed or direct format, palette bank and a 6-bit blend weight. It also receives one region-wide stacking override. Indexed pixels are resolved through an internal colour palette that software loads through a write port. Direct pixels are 5-6-5 RGB values expanded to 8 bits per channel.

The planes are stacked according to the default order or the override. Each plane is then alpha-blended, bottom to top, over everything beneath it. The block emits a 24-bit colour and a 2-bit attribute code that tells a downstream mixer whether OSD content is present. It is intended to sit between the plane fetch logic and the video output formatter of a display pipeline.

Top module: `osd_compositor`

## Requirements
- R1: A pixel sampled with `pix_valid` high on a rising edge appears on `out_pix`/`out_attr` with `out_valid` high exactly two rising edges later. Edges with `pix_valid` low produce no output, so `out_valid` stays low in the matching cycle.
- R2: While `rst_n` is low and after its release, before any pixel, `out_valid`, `out_pix` and `out_attr` are all zero.
- R3: Each plane is blended over the colour beneath it per channel as round((w*osd + (63-w)*below)/63), with ties rounded up. A weight of 0 leaves the colour beneath unchanged, so a dot whose four weights are all 0 outputs the backdrop exactly.
- R4: A plane with weight 63 fully replaces everything beneath it.
- R5: With `prio_ovr` low, the stacking order from top to bottom is plane 3, plane 2, plane 1, plane 0, then the backdrop.
- R6: With `prio_ovr` high, stacking level k (k=0 is the top) is taken by the plane whose number is in `prio_order[2k+1:2k]`. The field is expected to hold a permutation of 0..3.
- R7: When `osd_indexed[p]` is 1, bits [7:0] of plane p's pixel index a 256-entry palette of 24-bit colours in the bank given by `osd_bank[p]`. Each plane chooses its bank independently.
- R8: When `osd_indexed[p]` is 0, plane p's 16-bit pixel is RGB 5-6-5, with red in [15:11], green in [10:5] and blue in [4:0]. Each channel is widened to 8 bits by appending its own top bits: R={r,r[4:2]}, G={g,g[5:4]}, B={b,b[4:2]}. Output colour is packed as {R,G,B}.
- R9: A palette write with `pal_wr_en` high stores `pal_wr_data` at bank `pal_wr_bank`, entry `pal_wr_idx`, on the rising edge. A lookup sampled on that same edge returns the previous content, and lookups sampled on later edges return the new one.
- R10: `out_attr` is 2'b10 when any plane has weight 63, otherwise 2'b01 when any plane has a non-zero weight, otherwise 2'b00. The value 2'b11 never occurs.
- R11: In indexed mode, bits [15:8] of the plane pixel have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pal_wr_en | input | 1 | Palette write strobe |
| pal_wr_bank | input | 1 | Palette bank to write |
| pal_wr_idx | input | 8 | Palette entry to write |
| pal_wr_data | input | 24 | Colour {R,G,B} to store |
| pix_valid | input | 1 | Dot present on the plane inputs |
| bd_pix | input | 24 | Backdrop colour {R,G,B} |
| osd_pix | input | 64 | Raw pixel of plane p in bits [16p+15:16p] |
| osd_indexed | input | 4 | Per plane: 1 indexed, 0 direct 5-6-5 |
| osd_bank | input | 4 | Per plane palette bank |
| osd_wt | input | 24 | Blend weight of plane p in bits [6p+5:6p] |
| prio_ovr | input | 1 | Use `prio_order` instead of the default stacking |
| prio_order | input | 8 | Plane number for each stacking level, level 0 on top |
| out_valid | output | 1 | Composite result valid |
| out_pix | output | 24 | Composite colour {R,G,B} |
| out_attr | output | 2 | Attribute code of the dot |

## Verification
Every composited dot is due on the outputs two rising edges after the edge that sampled it. One edge registers the palette lookup together with the delayed plane data, and the second registers the blended result. The bench stamps each expected dot with the cycle number it is due in. It then compares colour, attribute and arrival cycle in the matching cycle, at the falling edge. Idle cycles between dots must not produce output. A palette write that coincides with a lookup is scored against the palette contents from before the write.

// File: rtl/osd_comp_pkg.sv
package osd_comp_pkg;
  localparam int CH_W   = 8;
  localparam int RGB_W  = 3 * CH_W;
  localparam int WT_W   = 6;
  localparam int WT_MAX = (1 << WT_W) - 1;
  localparam int PIX_W  = 16;
  localparam int IDX_W  = 8;

  typedef logic [RGB_W-1:0] rgb_t;

  typedef enum logic [1:0] {
    ATTR_BACKDROP = 2'b00,
    ATTR_BLEND    = 2'b01,
    ATTR_OPAQUE   = 2'b10
  } attr_e;

  // one channel: weighted sum over WT_MAX, rounded to nearest
  function automatic logic [CH_W-1:0] mix_ch(input logic [WT_W-1:0] w,
                                             input logic [CH_W-1:0] fg,
                                             input logic [CH_W-1:0] bg);
    localparam int AW = CH_W + WT_W + 1;
    logic [AW-1:0] wa, wb, fa, ba, acc;
    wa  = AW'(w);
    wb  = AW'(WT_MAX) - wa;
    fa  = AW'(fg);
    ba  = AW'(bg);
    acc = wa * fa + wb * ba + AW'(WT_MAX / 2);
    acc = acc / AW'(WT_MAX);
    return acc[CH_W-1:0];
  endfunction

  function automatic rgb_t mix_rgb(input logic [WT_W-1:0] w, input rgb_t fg, input rgb_t bg);
    rgb_t r;
    for (int c = 0; c < 3; c++)
      r[c*CH_W +: CH_W] = mix_ch(w, fg[c*CH_W +: CH_W], bg[c*CH_W +: CH_W]);
    return r;
  endfunction

  // 5-6-5 to 8-8-8 by replicating top bits
  function automatic rgb_t expand565(input logic [PIX_W-1:0] p);
    return {p[15:11], p[15:13], p[10:5], p[10:9], p[4:0], p[4:2]};
  endfunction
endpackage

// File: rtl/osd_palette.sv
module osd_palette import osd_comp_pkg::*; #(
  parameter  int NPLANE = 4,
  parameter  int NBANK  = 2,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int AW     = BANK_W + IDX_W,
  localparam int DEPTH  = NBANK << IDX_W
) (
  input  logic                      clk,
  input  logic                      wr_en,
  input  logic [BANK_W-1:0]         wr_bank,
  input  logic [IDX_W-1:0]          wr_idx,
  input  rgb_t                      wr_data,
  input  logic [NPLANE*BANK_W-1:0]  rd_bank,
  input  logic [NPLANE*IDX_W-1:0]   rd_idx,
  output logic [NPLANE*RGB_W-1:0]   rd_data
);
  rgb_t mem [DEPTH];
  logic [AW-1:0] wr_addr;

  assign wr_addr = {wr_bank, wr_idx};

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // one registered read port per plane; same-edge write is not seen
  always_ff @(posedge clk) begin
    for (int p = 0; p < NPLANE; p++)
      rd_data[p*RGB_W +: RGB_W] <= mem[{rd_bank[p*BANK_W +: BANK_W], rd_idx[p*IDX_W +: IDX_W]}];
  end
endmodule

// File: rtl/osd_blend_stack.sv
module osd_blend_stack import osd_comp_pkg::*; #(
  parameter  int NPLANE = 4,
  localparam int SLOT_W = $clog2(NPLANE)
) (
  input  rgb_t                      bd,
  input  logic [NPLANE*RGB_W-1:0]   col,
  input  logic [NPLANE*WT_W-1:0]    wt,
  input  logic                      ovr_en,
  input  logic [NPLANE*SLOT_W-1:0]  order,
  output rgb_t                      mix,
  output logic [1:0]                attr,
  output rgb_t                      top_col,
  output logic [WT_W-1:0]           top_wt
);
  rgb_t              lvl  [NPLANE+1];
  logic [SLOT_W-1:0] pick [NPLANE];

  assign lvl[NPLANE] = bd;

  // level 0 is the top; blend from the bottom level upwards
  for (genvar s = 0; s < NPLANE; s++) begin : g_slot
    assign pick[s] = ovr_en ? order[s*SLOT_W +: SLOT_W] : SLOT_W'(NPLANE - 1 - s);
    assign lvl[s]  = mix_rgb(wt[pick[s]*WT_W +: WT_W], col[pick[s]*RGB_W +: RGB_W], lvl[s+1]);
  end

  assign mix     = lvl[0];
  assign top_col = col[pick[0]*RGB_W +: RGB_W];
  assign top_wt  = wt[pick[0]*WT_W +: WT_W];

  logic any_vis, any_opq;
  always_comb begin
    any_vis = 1'b0;
    any_opq = 1'b0;
    for (int p = 0; p < NPLANE; p++) begin
      any_vis = any_vis | (wt[p*WT_W +: WT_W] != '0);
      any_opq = any_opq | (wt[p*WT_W +: WT_W] == WT_W'(WT_MAX));
    end
    attr = any_opq ? ATTR_OPAQUE : (any_vis ? ATTR_BLEND : ATTR_BACKDROP);
  end
endmodule

// File: rtl/osd_compositor.sv
module osd_compositor import osd_comp_pkg::*; #(
  parameter  int NPLANE = 4,
  parameter  int NBANK  = 2,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int SLOT_W = $clog2(NPLANE)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pal_wr_en,
  input  logic [BANK_W-1:0]         pal_wr_bank,
  input  logic [IDX_W-1:0]          pal_wr_idx,
  input  logic [RGB_W-1:0]          pal_wr_data,
  input  logic                      pix_valid,
  input  logic [RGB_W-1:0]          bd_pix,
  input  logic [NPLANE*PIX_W-1:0]   osd_pix,
  input  logic [NPLANE-1:0]         osd_indexed,
  input  logic [NPLANE*BANK_W-1:0]  osd_bank,
  input  logic [NPLANE*WT_W-1:0]    osd_wt,
  input  logic                      prio_ovr,
  input  logic [NPLANE*SLOT_W-1:0]  prio_order,
  output logic                      out_valid,
  output logic [RGB_W-1:0]          out_pix,
  output logic [1:0]                out_attr
);
  logic [NPLANE*RGB_W-1:0]  direct_rgb, pal_rgb, plane_rgb;
  logic [NPLANE*IDX_W-1:0]  rd_idx;

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane_in
    assign direct_rgb[p*RGB_W +: RGB_W] = expand565(osd_pix[p*PIX_W +: PIX_W]);
    assign rd_idx[p*IDX_W +: IDX_W]     = osd_pix[p*PIX_W +: IDX_W];
  end

  osd_palette #(.NPLANE(NPLANE), .NBANK(NBANK)) u_pal (
    .clk     (clk),
    .wr_en   (pal_wr_en),
    .wr_bank (pal_wr_bank),
    .wr_idx  (pal_wr_idx),
    .wr_data (pal_wr_data),
    .rd_bank (osd_bank),
    .rd_idx  (rd_idx),
    .rd_data (pal_rgb)
  );

  // stage 1: plane data delayed to line up with the palette read
  logic                      s1_valid;
  rgb_t                      s1_bd;
  logic [NPLANE*RGB_W-1:0]   s1_direct;
  logic [NPLANE-1:0]         s1_indexed;
  logic [NPLANE*WT_W-1:0]    s1_wt;
  logic                      s1_ovr;
  logic [NPLANE*SLOT_W-1:0]  s1_order;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid   <= 1'b0;
      s1_bd      <= '0;
      s1_direct  <= '0;
      s1_indexed <= '0;
      s1_wt      <= '0;
      s1_ovr     <= 1'b0;
      s1_order   <= '0;
    end else begin
      s1_valid   <= pix_valid;
      s1_bd      <= bd_pix;
      s1_direct  <= direct_rgb;
      s1_indexed <= osd_indexed;
      s1_wt      <= osd_wt;
      s1_ovr     <= prio_ovr;
      s1_order   <= prio_order;
    end
  end

  for (genvar p = 0; p < NPLANE; p++) begin : g_plane_sel
    assign plane_rgb[p*RGB_W +: RGB_W] = s1_indexed[p] ? pal_rgb[p*RGB_W +: RGB_W]
                                                       : s1_direct[p*RGB_W +: RGB_W];
  end

  rgb_t            mix_rgb_w, top_col;
  logic [1:0]      mix_attr;
  logic [WT_W-1:0] top_wt;

  osd_blend_stack #(.NPLANE(NPLANE)) u_stack (
    .bd      (s1_bd),
    .col     (plane_rgb),
    .wt      (s1_wt),
    .ovr_en  (s1_ovr),
    .order   (s1_order),
    .mix     (mix_rgb_w),
    .attr    (mix_attr),
    .top_col (top_col),
    .top_wt  (top_wt)
  );

  // stage 2: registered composite
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_attr  <= ATTR_BACKDROP;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_pix  <= mix_rgb_w;
        out_attr <= mix_attr;
      end
    end
  end

  logic s1_all_clear;
  logic s1_top_opaque;
  assign s1_all_clear  = s1_valid && (s1_wt == '0);
  assign s1_top_opaque = s1_valid && (top_wt == WT_W'(WT_MAX));

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> out_valid);                                          // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_valid |=> !out_valid);                                        // R1
  AST_CLEAR_PASSES_BD: assert property (@(posedge clk) disable iff (!rst_n)
    s1_all_clear |=> (out_pix == $past(s1_bd)) && (out_attr == ATTR_BACKDROP)); // R3
  AST_TOP_OPAQUE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    s1_top_opaque |=> (out_pix == $past(top_col)) && (out_attr == ATTR_OPAQUE)); // R4
  AST_ATTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_attr));                                // R10
endmodule

// File: tb/tb_osd_compositor.sv
module tb_osd_compositor;
  localparam int NP = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pal_wr_en = 1'b0;
  logic [0:0]  pal_wr_bank = '0;
  logic [7:0]  pal_wr_idx = '0;
  logic [23:0] pal_wr_data = '0;
  logic        pix_valid = 1'b0;
  logic [23:0] bd_pix = '0;
  logic [63:0] osd_pix = '0;
  logic [3:0]  osd_indexed = '0;
  logic [3:0]  osd_bank = '0;
  logic [23:0] osd_wt = '0;
  logic        prio_ovr = 1'b0;
  logic [7:0]  prio_order = '0;
  logic        out_valid;
  logic [23:0] out_pix;
  logic [1:0]  out_attr;

  osd_compositor dut (
    .clk(clk), .rst_n(rst_n),
    .pal_wr_en(pal_wr_en), .pal_wr_bank(pal_wr_bank), .pal_wr_idx(pal_wr_idx),
    .pal_wr_data(pal_wr_data), .pix_valid(pix_valid), .bd_pix(bd_pix),
    .osd_pix(osd_pix), .osd_indexed(osd_indexed), .osd_bank(osd_bank),
    .osd_wt(osd_wt), .prio_ovr(prio_ovr), .prio_order(prio_order),
    .out_valid(out_valid), .out_pix(out_pix), .out_attr(out_attr)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  typedef struct {
    logic [23:0] pix;
    logic [1:0]  attr;
    int          due;
    string       tag;
  } exp_t;
  exp_t sb [$];

  logic [23:0] pal_model [2][256];

  function automatic logic [7:0] bmix8(int w, logic [7:0] f, logic [7:0] b);
    int num, r;
    num = w * int'(f) + (63 - w) * int'(b);
    r = (2 * num + 63) / 126;
    return r[7:0];
  endfunction

  function automatic logic [23:0] bmix(int w, logic [23:0] f, logic [23:0] b);
    return {bmix8(w, f[23:16], b[23:16]), bmix8(w, f[15:8], b[15:8]), bmix8(w, f[7:0], b[7:0])};
  endfunction

  function automatic logic [23:0] widen(logic [15:0] p);
    int r, g, b;
    r = int'(p[15:11]); g = int'(p[10:5]); b = int'(p[4:0]);
    r = (r << 3) | (r >> 2);
    g = (g << 2) | (g >> 4);
    b = (b << 3) | (b >> 2);
    return {r[7:0], g[7:0], b[7:0]};
  endfunction

  task automatic drive(input logic [23:0] bd, input logic [63:0] pix, input logic [3:0] idxm,
                       input logic [3:0] bank, input logic [23:0] wt, input logic ovr,
                       input logic [7:0] order, input string tag);
    exp_t e;
    logic [23:0] cur, col;
    bit opq, vis;
    int p, w;
    @(negedge clk);
    pal_wr_en = 1'b0;
    pix_valid = 1'b1; bd_pix = bd; osd_pix = pix; osd_indexed = idxm;
    osd_bank = bank; osd_wt = wt; prio_ovr = ovr; prio_order = order;
    cur = bd; opq = 0; vis = 0;
    for (int s = NP - 1; s >= 0; s--) begin
      p = ovr ? int'(order[2*s +: 2]) : (NP - 1 - s);
      w = int'(wt[6*p +: 6]);
      col = idxm[p] ? pal_model[bank[p]][pix[16*p +: 8]] : widen(pix[16*p +: 16]);
      cur = bmix(w, col, cur);
      if (w == 63) opq = 1;
      if (w != 0) vis = 1;
    end
    e.pix = cur;
    e.attr = opq ? 2'b10 : (vis ? 2'b01 : 2'b00);
    e.due = cyc + 2;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_valid = 1'b0;
      pal_wr_en = 1'b0;
    end
  endtask

  task automatic pal_write(input logic bank, input logic [7:0] idx, input logic [23:0] d);
    @(negedge clk);
    pix_valid = 1'b0;
    pal_wr_en = 1'b1; pal_wr_bank = bank; pal_wr_idx = idx; pal_wr_data = d;
    pal_model[bank][idx] = d;
  endtask

  // write issued on the same edge that samples the previously driven dot
  task automatic pal_write_now(input logic bank, input logic [7:0] idx, input logic [23:0] d);
    pal_wr_en = 1'b1; pal_wr_bank = bank; pal_wr_idx = idx; pal_wr_data = d;
    pal_model[bank][idx] = d;
  endtask

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid && !finished) begin
      if (sb.size() == 0) begin
        check(0, "R1 output with no dot pending", {8'h0, out_pix}, 32'h0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(out_pix == e.pix, {e.tag, " colour"}, {8'h0, out_pix}, {8'h0, e.pix});
        check(out_attr == e.attr, {e.tag, " R10 attr"}, {30'h0, out_attr}, {30'h0, e.attr});
        check(cyc == e.due, {e.tag, " R1 arrival cycle"}, cyc, e.due);
      end
    end
  end

  function automatic logic [63:0] pk16(logic [15:0] d, logic [15:0] c, logic [15:0] b, logic [15:0] a);
    return {d, c, b, a};
  endfunction

  function automatic logic [23:0] pkw(int d, int c, int b, int a);
    return {6'(d), 6'(c), 6'(b), 6'(a)};
  endfunction

  initial begin
    logic [31:0] r0, r1, r2, r3;
    logic [7:0]  ord;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_pix == '0 && out_attr == '0, "R2 in reset",
          {7'h0, out_valid, out_pix}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(out_valid == 1'b0 && out_pix == '0 && out_attr == '0, "R2 after reset",
          {7'h0, out_valid, out_pix}, 32'h0);

    // R7 palette load, both banks
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < 256; i++) begin
        logic [7:0] v;
        v = 8'(i);
        pal_write(b[0], v, {v ^ 8'h5A, 8'(i * 3 + b * 17), ~v ^ 8'(b * 8'h81)});
      end
    idle(2);

    drive(24'h123456, pk16(16'hFFFF, 16'h1234, 16'hABCD, 16'h0F0F), 4'h0, 4'h0,
          pkw(0, 0, 0, 0), 1'b0, 8'h00, "R3 all weights zero");
    drive(24'h000000, pk16(16'h0, 16'h0, 16'h0, 16'hF81F), 4'h0, 4'h0,
          pkw(0, 0, 0, 63), 1'b0, 8'h00, "R8 R4 plane0 opaque 565");
    drive(24'h808080, pk16(16'h07E0, 16'h001F, 16'hF800, 16'h8410), 4'h0, 4'h0,
          pkw(63, 63, 63, 63), 1'b0, 8'h00, "R5 all opaque plane3 on top");
    drive(24'h808080, pk16(16'h07E0, 16'h001F, 16'hF800, 16'h8410), 4'h0, 4'h0,
          pkw(0, 63, 63, 63), 1'b0, 8'h00, "R5 plane2 next");
    idle(1);
    drive(24'hFF0000, pk16(16'hFFFF, 16'h0, 16'h0, 16'h001F), 4'h0, 4'h0,
          pkw(10, 0, 0, 32), 1'b0, 8'h00, "R3 partial blend");
    drive(24'h010203, pk16(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0), 4'h0, 4'h0,
          pkw(1, 62, 31, 17), 1'b0, 8'h00, "R3 mixed weights");
    drive(24'h808080, pk16(16'h07E0, 16'h001F, 16'hF800, 16'h8410), 4'h0, 4'h0,
          pkw(63, 63, 63, 63), 1'b1, 8'b11_10_01_00, "R6 plane0 on top");
    drive(24'h808080, pk16(16'h07E0, 16'h001F, 16'hF800, 16'h8410), 4'h0, 4'h0,
          pkw(63, 40, 63, 20), 1'b1, 8'b00_10_11_01, "R6 reordered blend");
    idle(2);
    drive(24'h203040, pk16(16'h0011, 16'h0022, 16'h0033, 16'h0044), 4'hF, 4'b1010,
          pkw(63, 0, 0, 0), 1'b0, 8'h00, "R7 indexed bank1 opaque");
    drive(24'h203040, pk16(16'h0011, 16'h0022, 16'h0033, 16'h0044), 4'hF, 4'b0101,
          pkw(20, 30, 40, 50), 1'b0, 8'h00, "R7 indexed banks mixed");
    drive(24'h203040, pk16(16'hFF11, 16'hA522, 16'h3C33, 16'h7744), 4'hF, 4'b0101,
          pkw(20, 30, 40, 50), 1'b0, 8'h00, "R11 upper bits ignored");
    drive(24'h000000, pk16(16'h0040, 16'h0, 16'h0, 16'h0), 4'h8, 4'b1000,
          pkw(63, 0, 0, 0), 1'b0, 8'h00, "R9 lookup on write edge sees old");
    pal_write_now(1'b1, 8'h40, 24'hC0FFEE);
    drive(24'h000000, pk16(16'h0040, 16'h0, 16'h0, 16'h0), 4'h8, 4'b1000,
          pkw(63, 0, 0, 0), 1'b0, 8'h00, "R9 lookup after write sees new");
    idle(3);

    // mixed stream with random gaps
    for (int k = 0; k < 80; k++) begin
      int rot;
      bit rev;
      r0 = $urandom; r1 = $urandom; r2 = $urandom; r3 = $urandom;
      rot = int'(r3[1:0]);
      rev = r3[2];
      for (int s = 0; s < NP; s++) begin
        int v;
        v = (s + rot) % NP;
        if (rev) v = NP - 1 - v;
        ord[2*s +: 2] = 2'(v);
      end
      if (r3[5:4] == 2'b00) r2[5:0] = 6'd63;
      if (r3[7:6] == 2'b00) r2[11:6] = 6'd0;
      drive(r0[23:0], {r1, r0}, r3[11:8], r3[15:12], r2[23:0], r3[16], ord, "R3 R7 stream");
      if (r3[19:18] == 2'b00) idle(1);
    end
    idle(5);
    check(sb.size() == 0, "R1 every dot delivered", sb.size(), 32'h0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", cyc, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule